// File: doc/BRIEF.md
# DMA Channel Register File with Shared Byte Pointer

This block keeps the 16-bit programming registers of a group of DMA channels: for each channel a base address, a base count and a current address. The host reaches them through an 8-bit port. One byte pointer, shared by every channel, selects the low or the high half of each access, and every access to a channel register inverts it. A write to the high half reloads the channel's current address from its base and tells the transfer engine to clear that channel's running count.

The transfer engine supplies each channel's running count and the channel's decrement bit. A read of an address register returns the current address moved by that count in the programmed direction. A read of a count register returns how much is left: the base count minus the running count. A parameter selects a byte-wide or a word-wide channel group. In the word-wide group the port offset is taken from the host address shifted down by one, and addresses and counts are held in word units scaled by two.

Top module: `dma_chanfile`

## Requirements
- R1: The port offset is `host_addr >> WSHIFT`. Offsets 0..7 select a channel register: channel = offset >> 1, and offset bit 0 chooses address (0) or count (1). Accesses to offsets 8..15 change no register, no pointer state and no `rdata`.
- R2: One byte pointer serves all channels. Each channel-register read or write uses its current value (0 = low byte, 1 = high byte) and then inverts it.
- R3: A low-byte write replaces only bits 7:0 of the selected base register. A high-byte write replaces only bits 15:8.
- R4: A high-byte write to either register of a channel loads that channel's `cur_addr` with its new base address shifted left by WSHIFT. It also raises `cnt_clr` for that channel alone for exactly one cycle after the write edge. A low-byte write leaves `cur_addr` unchanged.
- R5: A count read returns the selected byte of ((base count << WSHIFT) - `xfer_cnt`) >> WSHIFT.
- R6: An address read returns the selected byte of (`cur_addr` + `xfer_cnt`) >> WSHIFT. When the channel's `dir_dec` bit is 1, it returns the selected byte of (`cur_addr` - `xfer_cnt`) >> WSHIFT instead.
- R7: `ptr_clr` or `master_clr` forces the pointer to 0 at the clock edge. This applies even when a channel access arrives in the same cycle.
- R8: When `wr_en` and `rd_en` are both high, only the write takes place, `rdata` keeps its value, and the pointer inverts once.
- R9: After reset every register, the pointer, `rdata` and `cnt_clr` are zero.
- R10: Read data is registered. `rdata` changes only at the edge that ends a channel-register read and holds at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | OFF_W+WSHIFT (4) | Host port address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Registered read byte |
| ptr_clr | input | 1 | Clear-byte-pointer command |
| master_clr | input | 1 | Master clear command (pointer part) |
| xfer_cnt | input | NCH x AW (4x16) | Running transfer count per channel |
| dir_dec | input | NCH (4) | Per-channel decrement-direction mode bit |
| cur_addr | output | NCH x AW (4x16) | Current address per channel |
| cnt_clr | output | NCH (4) | One-cycle request to zero a channel's running count |

## Verification
The assertions assume the host never asserts a strobe while `rst_n` is low. They also assume `xfer_cnt` and `dir_dec` are stable across the edge that takes a read. The stimulus changes inputs only on falling edges and sets the counts and direction bits before the read strobe rises. Each scenario first issues a pointer clear, so every expected byte follows from a known pointer phase. Ignored accesses are exposed by a write that follows them: it shows whether the pointer moved.

// File: rtl/dma_chanfile_pkg.sv
package dma_chanfile_pkg;

    // decoded host access, already qualified by channel-region hit
    typedef struct packed {
        logic is_cnt;
        logic wr;
        logic rd;
    } acc_t;

    // top-level sequential state
    typedef struct packed {
        logic       ptr;
        logic [7:0] rdata;
    } top_st_t;

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
    import dma_chanfile_pkg::*;
#(
    parameter int WSHIFT = 0,
    parameter int CH_W   = 2,
    parameter int OFF_W  = CH_W + 2,
    parameter int ADDR_W = OFF_W + WSHIFT
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [CH_W-1:0]   chan,
    output acc_t              acc
);
    logic [OFF_W-1:0] off;
    logic             hit;

    always_comb begin
        off        = host_addr[ADDR_W-1:WSHIFT];
        hit        = ~off[OFF_W-1];
        chan       = off[OFF_W-2:1];
        acc.is_cnt = off[0];
        acc.wr     = hit & wr_en;
        acc.rd     = hit & rd_en & ~wr_en;   // write wins
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chanfile_pkg::*;
#(
    parameter int WSHIFT = 0,
    parameter int AW     = 16 + WSHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  acc_t          acc,
    input  logic          hi,
    input  logic [7:0]    wdata,
    output logic [15:0]   base_cnt,
    output logic [AW-1:0] cur_addr,
    output logic          cnt_clr
);
    typedef struct packed {
        logic [15:0]   base_a;
        logic [15:0]   base_c;
        logic [AW-1:0] cur;
        logic          clr;
    } ch_st_t;

    ch_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        if (sel && acc.wr) begin
            if (!hi) begin
                if (acc.is_cnt) st_d.base_c[7:0] = wdata;
                else            st_d.base_a[7:0] = wdata;
            end else begin
                if (acc.is_cnt) st_d.base_c[15:8] = wdata;
                else            st_d.base_a[15:8] = wdata;
                st_d.cur = AW'(st_d.base_a) << WSHIFT;
                st_d.clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_cnt = st_q.base_c;
    assign cur_addr = st_q.cur;
    assign cnt_clr  = st_q.clr;

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && acc.wr && hi) |=> (cur_addr == (AW'(st_q.base_a) << WSHIFT)) && cnt_clr);

    // R4
    low_noreload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && acc.wr && !hi) |=> $stable(cur_addr) && !cnt_clr);

    // R3
    low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && acc.wr && !hi && !acc.is_cnt) |=> st_q.base_a[15:8] == $past(st_q.base_a[15:8]));
endmodule

// File: rtl/dma_readback.sv
module dma_readback #(
    parameter int NCH    = 4,
    parameter int WSHIFT = 0,
    parameter int AW     = 16 + WSHIFT,
    parameter int CH_W   = $clog2(NCH)
) (
    input  logic [NCH-1:0][AW-1:0] cur_addr,
    input  logic [NCH-1:0][15:0]   base_cnt,
    input  logic [NCH-1:0][AW-1:0] xfer_cnt,
    input  logic [NCH-1:0]         dir_dec,
    input  logic [CH_W-1:0]        chan,
    input  logic                   is_cnt,
    input  logic                   hi,
    output logic [7:0]             byte_out
);
    logic [AW-1:0] val;
    logic [15:0]   scaled;

    always_comb begin
        if (is_cnt)
            val = (AW'(base_cnt[chan]) << WSHIFT) - xfer_cnt[chan];
        else if (dir_dec[chan])
            val = cur_addr[chan] - xfer_cnt[chan];
        else
            val = cur_addr[chan] + xfer_cnt[chan];
        scaled   = 16'(val >> WSHIFT);
        byte_out = hi ? scaled[15:8] : scaled[7:0];
    end
endmodule

// File: rtl/dma_chanfile.sv
module dma_chanfile
    import dma_chanfile_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int WSHIFT = 0,
    parameter int CH_W   = $clog2(NCH),
    parameter int OFF_W  = CH_W + 2,
    parameter int ADDR_W = OFF_W + WSHIFT,
    parameter int AW     = 16 + WSHIFT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    input  logic                   ptr_clr,
    input  logic                   master_clr,
    input  logic [NCH-1:0][AW-1:0] xfer_cnt,
    input  logic [NCH-1:0]         dir_dec,
    output logic [NCH-1:0][AW-1:0] cur_addr,
    output logic [NCH-1:0]         cnt_clr
);
    logic [CH_W-1:0]      chan;
    acc_t                 acc;
    logic [NCH-1:0][15:0] base_cnt;
    logic [7:0]           rd_byte;
    logic                 clr_any;
    top_st_t              st_d, st_q;

    dma_port_decode #(.WSHIFT(WSHIFT), .CH_W(CH_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_dec (
        .host_addr(host_addr), .wr_en(wr_en), .rd_en(rd_en), .chan(chan), .acc(acc)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_chan_regs #(.WSHIFT(WSHIFT), .AW(AW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .sel(chan == CH_W'(g)), .acc(acc), .hi(st_q.ptr), .wdata(wdata),
            .base_cnt(base_cnt[g]), .cur_addr(cur_addr[g]), .cnt_clr(cnt_clr[g])
        );
    end

    dma_readback #(.NCH(NCH), .WSHIFT(WSHIFT), .AW(AW), .CH_W(CH_W)) u_rb (
        .cur_addr(cur_addr), .base_cnt(base_cnt), .xfer_cnt(xfer_cnt), .dir_dec(dir_dec),
        .chan(chan), .is_cnt(acc.is_cnt), .hi(st_q.ptr), .byte_out(rd_byte)
    );

    assign clr_any = ptr_clr | master_clr;

    always_comb begin
        st_d = st_q;
        if (clr_any)               st_d.ptr = 1'b0;
        else if (acc.wr || acc.rd) st_d.ptr = ~st_q.ptr;
        if (acc.rd)                st_d.rdata = rd_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    // R2
    ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc.wr || acc.rd) && !clr_any) |=> st_q.ptr != $past(st_q.ptr));

    // R7
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_any |=> !st_q.ptr);

    // R1
    ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(acc.wr || acc.rd) && !clr_any) |=> $stable(st_q.ptr));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc.rd |=> $stable(rdata));

    // R4
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnt_clr));
endmodule

// File: tb/dma_chanfile_bench.sv
module dma_chanfile_bench;
    localparam int NCH = 4;
    localparam int AW  = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [3:0]             host_addr = '0;
    logic                   wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]             wdata = '0;
    logic [7:0]             rdata;
    logic                   ptr_clr = 1'b0, master_clr = 1'b0;
    logic [NCH-1:0][AW-1:0] xfer_cnt = '0;
    logic [NCH-1:0]         dir_dec = '0;
    logic [NCH-1:0][AW-1:0] cur_addr;
    logic [NCH-1:0]         cnt_clr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dma_chanfile u_dma_chanfile (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ptr_clr(ptr_clr), .master_clr(master_clr),
        .xfer_cnt(xfer_cnt), .dir_dec(dir_dec), .cur_addr(cur_addr), .cnt_clr(cnt_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at falling edge, return just after the rising edge
    task automatic bus(input logic [3:0] off, input logic w, input logic r,
                       input logic [7:0] d, input logic pc, input logic mc);
        @(negedge clk);
        host_addr = off; wr_en = w; rd_en = r; wdata = d; ptr_clr = pc; master_clr = mc;
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; ptr_clr = 0; master_clr = 0;
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d); bus(off, 1, 0, d, 0, 0); endtask
    task automatic rd(input logic [3:0] off); bus(off, 0, 1, 8'h00, 0, 0); endtask
    task automatic pclr(); bus(4'hF, 0, 0, 8'h00, 1, 0); endtask

    task automatic t_reset();
        chk("R9 rdata", rdata, 0);
        chk("R9 cur_addr", cur_addr, 0);
        chk("R9 cnt_clr", cnt_clr, 0);
    endtask

    task automatic t_addr_path();
        pclr();
        wr(4'd2, 8'h34);
        chk("R4 no reload on low", cur_addr[1], 16'h0000);
        wr(4'd2, 8'h12);
        chk("R4 reload", cur_addr[1], 16'h1234);
        chk("R4 cnt_clr pulse", cnt_clr, 4'b0010);
        bus(4'hF, 0, 0, 0, 0, 0);
        chk("R4 cnt_clr one cycle", cnt_clr, 4'b0000);
        xfer_cnt[1] = 16'h0010;
        rd(4'd2); chk("R6 inc low", rdata, 8'h44);
        rd(4'd2); chk("R6 inc high", rdata, 8'h12);
        dir_dec[1] = 1'b1;
        rd(4'd2); chk("R6 dec low", rdata, 8'h24);
        rd(4'd2); chk("R6 dec high", rdata, 8'h12);
        dir_dec[1] = 1'b0; xfer_cnt[1] = '0;
    endtask

    task automatic t_count_path();
        pclr();
        wr(4'd7, 8'h00);
        wr(4'd7, 8'h01);
        chk("R4 count high write pulses", cnt_clr, 4'b1000);
        xfer_cnt[3] = 16'h0005;
        rd(4'd7); chk("R5 remaining low", rdata, 8'hFB);
        rd(4'd7); chk("R5 remaining high", rdata, 8'h00);
        xfer_cnt[3] = '0;
    endtask

    task automatic t_byte_replace();
        pclr();
        wr(4'd2, 8'hAA);                       // ptr -> 1
        chk("R4 low keeps cur", cur_addr[1], 16'h1234);
        pclr();                                // R7 from ptr=1
        rd(4'd2); chk("R7 cleared ptr reads low", rdata, 8'h34);
        wr(4'd2, 8'h77);                       // high byte, base now 77AA
        chk("R3 halves", cur_addr[1], 16'h77AA);
    endtask

    task automatic t_shared_ptr();
        pclr();
        wr(4'd0, 8'h11);                       // ch0 low
        wr(4'd4, 8'h66);                       // ch2 high (shared ptr)
        chk("R2 shared ptr", cur_addr[2], 16'h6600);
        chk("R2 other channel", cur_addr[0], 16'h0000);
    endtask

    task automatic t_ignored();
        pclr();
        wr(4'd9, 8'hFF);
        rd(4'd12);
        chk("R1 rdata unchanged", rdata, 8'h34);
        wr(4'd0, 8'h22);
        wr(4'd0, 8'h33);
        chk("R1 ptr untouched", cur_addr[0], 16'h3322);
    endtask

    task automatic t_simul();
        pclr();
        bus(4'd0, 1, 1, 8'h44, 0, 0);
        chk("R8 rdata held", rdata, 8'h34);
        wr(4'd0, 8'h55);
        chk("R8 single toggle", cur_addr[0], 16'h5544);
    endtask

    task automatic t_master();
        pclr();
        wr(4'd6, 8'h01);                       // ptr -> 1
        bus(4'hF, 0, 0, 0, 0, 1);
        wr(4'd6, 8'h02);
        wr(4'd6, 8'h03);
        chk("R7 master clear", cur_addr[3], 16'h0302);
    endtask

    task automatic t_clr_vs_access();
        pclr();
        bus(4'd4, 1, 0, 8'h9C, 1, 0);          // low write, then ptr forced 0
        wr(4'd4, 8'h5A);                       // low again
        wr(4'd4, 8'h81);
        chk("R7 clear beats toggle", cur_addr[2], 16'h815A);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_addr_path();
        t_count_path();
        t_byte_replace();
        t_shared_ptr();
        t_ignored();
        t_simul();
        t_master();
        t_clr_vs_access();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule